// File: doc/BRIEF.md
# Sixteen-bit System Address Decoder

This block sits between an 8-bit processor and the memories and peripherals of a 16-bit address space. On every access it classifies the address into one of ten regions and reports that region and the byte offset inside it. It returns read data from the matching source and steers stores to the right destination. Reads are combinational from address to data. Stores take effect on the rising clock edge while the write strobe is high.

Cartridge ROM is external. The decoder forms the full ROM address from the in-bank offset and, in the switchable window, the bank number it is given. Stores aimed at the ROM area never change ROM. Instead they become commands on a bank-controller port. Video RAM, both work RAM areas and high RAM are internal byte arrays whose depth is set by parameters. The mirror areas reuse the same work RAM storage. The I/O block is reached through a combinational read path and a registered write strobe. The interrupt-enable byte is held locally and driven out.

Top module: `sys_addr_dec`

## Requirements
- R1: `region_o` encodes the region as ROM-fixed=0 (0x0000-0x3FFF), ROM-switchable=1 (0x4000-0x7FFF), video=2 (0x8000-0x9FFF), external=3 (0xA000-0xBFFF), work-low=4 (0xC000-0xCFFF and its mirror 0xE000-0xEFFF), work-switchable=5 (0xD000-0xDFFF and its mirror 0xF000-0xFDFF), sprite=6 (0xFE00-0xFEFF), I/O=7 (0xFF00-0xFF7F), high RAM=8 (0xFF80-0xFFFE) and interrupt-enable=9 (0xFFFF). `offset_o` is the address masked to 14, 14, 13, 13, 12, 12, 8, 7, 7 and 0 bits respectively.
- R2: A ROM read drives `rom_addr_o` = {0, offset} in the fixed area and {`rom_bank_i`, offset} in the switchable window. `rdata_o` equals `rom_rdata_i`.
- R3: A store anywhere in 0x0000-0x7FFF raises `mbc_we_o` for exactly the following cycle, with `mbc_addr_o` = address bits [14:0] and `mbc_wdata_o` = the data. No storage changes.
- R4: A store in 0x8000-0x9FFF writes video storage, indexed by the low VRAM_AW offset bits (default 9). In the following cycle it raises `vram_we_o` with `vram_off_o` = address bits [12:0]. Reads return the stored byte.
- R5: The external and sprite regions read 0x00. Stores to them raise no strobe and change nothing.
- R6: 0xC000-0xCFFF and 0xE000-0xEFFF reach the same work-low bytes, indexed by the low WRAM_AW offset bits (default 8).
- R7: 0xD000-0xDFFF and 0xF000-0xFDFF reach the same switchable work bank, chosen by `wram_bank_i`. A bank value of 0 selects bank 1. Distinct banks, and the work-low bytes, are separate storage.
- R8: In the I/O region `io_addr_o` = address bits [6:0] and `rdata_o` = `io_rdata_i`, both combinational. A store raises `io_we_o` in the following cycle, with `io_waddr_o` = address bits [6:0] and `io_wdata_o` = the data.
- R9: 0xFF80-0xFFFE read back the last byte stored there.
- R10: A store to 0xFFFF loads the interrupt-enable byte, which `ie_o` shows from the next cycle and reads return. Any other store leaves it unchanged.
- R11: While `rst_ni` is low, `mbc_we_o`, `vram_we_o` and `io_we_o` are 0 and `ie_o` is 0x00.
- R12: At most one of `mbc_we_o`, `vram_we_o` and `io_we_o` is high in a cycle. Each is high only in the cycle after a store to its region.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 16 | Access address |
| wdata_i | input | 8 | Store data |
| we_i | input | 1 | Store strobe |
| rdata_o | output | 8 | Read data |
| region_o | output | 4 | Region code |
| offset_o | output | 14 | Offset inside region |
| rom_addr_o | output | BANK_W+14 | External ROM address |
| rom_rdata_i | input | 8 | External ROM data |
| rom_bank_i | input | BANK_W | Switchable ROM bank number |
| mbc_we_o | output | 1 | Bank-controller command strobe |
| mbc_addr_o | output | 15 | Bank-controller command address |
| mbc_wdata_o | output | 8 | Bank-controller command data |
| vram_we_o | output | 1 | Video RAM written strobe |
| vram_off_o | output | 13 | Offset of video RAM store |
| wram_bank_i | input | WRAM_BW | Switchable work RAM bank |
| io_addr_o | output | 7 | I/O read offset |
| io_rdata_i | input | 8 | I/O read data |
| io_we_o | output | 1 | I/O write strobe |
| io_waddr_o | output | 7 | I/O write offset |
| io_wdata_o | output | 8 | I/O write data |
| ie_o | output | 8 | Interrupt-enable byte |

## Verification
Because the outward strobes are registered, the strobe left by one store is present in the same cycle as the decode of the next store. The bench provokes this with a ROM-area store followed directly by an I/O store. In the middle cycle it expects `mbc_we_o` high with the first command while the I/O store is being decoded. One cycle later it expects only `io_we_o` carrying the second store. A third cycle with no store must show all strobes low.

// File: rtl/sad_pkg.sv
package sad_pkg;
  typedef enum logic [3:0] {
    RG_ROM0  = 4'd0,
    RG_ROMX  = 4'd1,
    RG_VRAM  = 4'd2,
    RG_XRAM  = 4'd3,
    RG_WRAM0 = 4'd4,
    RG_WRAMX = 4'd5,
    RG_OAM   = 4'd6,
    RG_IO    = 4'd7,
    RG_HRAM  = 4'd8,
    RG_IE    = 4'd9
  } region_e;

  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned OFF_W  = 14;

  localparam logic [ADDR_W-1:0] OAM_BASE  = 16'hFE00;
  localparam logic [ADDR_W-1:0] IO_BASE   = 16'hFF00;
  localparam logic [ADDR_W-1:0] HRAM_BASE = 16'hFF80;
  localparam logic [ADDR_W-1:0] IE_ADDR   = 16'hFFFF;
endpackage

// File: rtl/sad_region_decode.sv
module sad_region_decode
  import sad_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o,
  output logic [OFF_W-1:0]  offset_o
);
  always_comb begin
    region_o = RG_ROM0;
    offset_o = '0;
    case (addr_i[15:12])
      4'h0, 4'h1, 4'h2, 4'h3: begin
        region_o = RG_ROM0;
        offset_o = addr_i[13:0];
      end
      4'h4, 4'h5, 4'h6, 4'h7: begin
        region_o = RG_ROMX;
        offset_o = addr_i[13:0];
      end
      4'h8, 4'h9: begin
        region_o = RG_VRAM;
        offset_o = {1'b0, addr_i[12:0]};
      end
      4'hA, 4'hB: begin
        region_o = RG_XRAM;
        offset_o = {1'b0, addr_i[12:0]};
      end
      4'hC, 4'hE: begin
        region_o = RG_WRAM0;
        offset_o = {2'b0, addr_i[11:0]};
      end
      4'hD: begin
        region_o = RG_WRAMX;
        offset_o = {2'b0, addr_i[11:0]};
      end
      default: begin
        // ascending checks inside the top page
        if (addr_i < OAM_BASE) begin
          region_o = RG_WRAMX;
          offset_o = {2'b0, addr_i[11:0]};
        end else if (addr_i < IO_BASE) begin
          region_o = RG_OAM;
          offset_o = {6'b0, addr_i[7:0]};
        end else if (addr_i < HRAM_BASE) begin
          region_o = RG_IO;
          offset_o = {7'b0, addr_i[6:0]};
        end else if (addr_i < IE_ADDR) begin
          region_o = RG_HRAM;
          offset_o = {7'b0, addr_i[6:0]};
        end else begin
          region_o = RG_IE;
          offset_o = '0;
        end
      end
    endcase
  end
endmodule

// File: rtl/sad_byte_ram.sv
module sad_byte_ram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];
endmodule

// File: rtl/sys_addr_dec.sv
module sys_addr_dec
  import sad_pkg::*;
#(
  parameter int unsigned BANK_W  = 8,
  parameter int unsigned VRAM_AW = 9,
  parameter int unsigned WRAM_AW = 8,
  parameter int unsigned WRAM_BW = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        addr_i,
  input  logic [7:0]         wdata_i,
  input  logic               we_i,
  output logic [7:0]         rdata_o,
  output logic [3:0]         region_o,
  output logic [13:0]        offset_o,
  output logic [BANK_W+13:0] rom_addr_o,
  input  logic [7:0]         rom_rdata_i,
  input  logic [BANK_W-1:0]  rom_bank_i,
  output logic               mbc_we_o,
  output logic [14:0]        mbc_addr_o,
  output logic [7:0]         mbc_wdata_o,
  output logic               vram_we_o,
  output logic [12:0]        vram_off_o,
  input  logic [WRAM_BW-1:0] wram_bank_i,
  output logic [6:0]         io_addr_o,
  input  logic [7:0]         io_rdata_i,
  output logic               io_we_o,
  output logic [6:0]         io_waddr_o,
  output logic [7:0]         io_wdata_o,
  output logic [7:0]         ie_o
);
  localparam int unsigned WIDX_W = WRAM_AW + WRAM_BW;
  localparam int unsigned HRAM_AW = 7;

  region_e              region;
  logic [OFF_W-1:0]     offset;
  logic [WRAM_BW-1:0]   wbank;
  logic [WIDX_W-1:0]    widx;
  logic [DATA_W-1:0]    vram_rd, wram_rd, hram_rd;
  logic                 vram_wr, wram_wr, hram_wr, rom_wr, io_wr, ie_wr;
  logic [DATA_W-1:0]    ie_q;

  sad_region_decode u_dec (
    .addr_i   (addr_i),
    .region_o (region),
    .offset_o (offset)
  );

  assign region_o = region;
  assign offset_o = offset;

  // ROM addressing: fixed bank is bank 0
  assign rom_addr_o = (region == RG_ROMX) ? {rom_bank_i, offset}
                                          : {{BANK_W{1'b0}}, offset};

  // switchable work bank: 0 behaves as 1
  always_comb begin
    if (region == RG_WRAM0)       wbank = '0;
    else if (wram_bank_i == '0)   wbank = WRAM_BW'(1);
    else                          wbank = wram_bank_i;
  end
  assign widx = {wbank, offset[WRAM_AW-1:0]};

  assign rom_wr  = we_i && (region == RG_ROM0 || region == RG_ROMX);
  assign vram_wr = we_i && (region == RG_VRAM);
  assign wram_wr = we_i && (region == RG_WRAM0 || region == RG_WRAMX);
  assign io_wr   = we_i && (region == RG_IO);
  assign hram_wr = we_i && (region == RG_HRAM);
  assign ie_wr   = we_i && (region == RG_IE);

  sad_byte_ram #(.AW(VRAM_AW), .DW(DATA_W)) u_vram (
    .clk_i   (clk_i),
    .we_i    (vram_wr),
    .addr_i  (offset[VRAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (vram_rd)
  );

  sad_byte_ram #(.AW(WIDX_W), .DW(DATA_W)) u_wram (
    .clk_i   (clk_i),
    .we_i    (wram_wr),
    .addr_i  (widx),
    .wdata_i (wdata_i),
    .rdata_o (wram_rd)
  );

  sad_byte_ram #(.AW(HRAM_AW), .DW(DATA_W)) u_hram (
    .clk_i   (clk_i),
    .we_i    (hram_wr),
    .addr_i  (offset[HRAM_AW-1:0]),
    .wdata_i (wdata_i),
    .rdata_o (hram_rd)
  );

  assign io_addr_o = offset[6:0];

  always_comb begin
    case (region)
      RG_ROM0, RG_ROMX:   rdata_o = rom_rdata_i;
      RG_VRAM:            rdata_o = vram_rd;
      RG_WRAM0, RG_WRAMX: rdata_o = wram_rd;
      RG_IO:              rdata_o = io_rdata_i;
      RG_HRAM:            rdata_o = hram_rd;
      RG_IE:              rdata_o = ie_q;
      default:            rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mbc_we_o    <= 1'b0;
      mbc_addr_o  <= '0;
      mbc_wdata_o <= '0;
      vram_we_o   <= 1'b0;
      vram_off_o  <= '0;
      io_we_o     <= 1'b0;
      io_waddr_o  <= '0;
      io_wdata_o  <= '0;
      ie_q        <= '0;
    end else begin
      mbc_we_o  <= rom_wr;
      vram_we_o <= vram_wr;
      io_we_o   <= io_wr;
      if (rom_wr) begin
        mbc_addr_o  <= addr_i[14:0];
        mbc_wdata_o <= wdata_i;
      end
      if (vram_wr) vram_off_o <= offset[12:0];
      if (io_wr) begin
        io_waddr_o <= offset[6:0];
        io_wdata_o <= wdata_i;
      end
      if (ie_wr) ie_q <= wdata_i;
    end
  end

  assign ie_o = ie_q;
endmodule

// File: rtl/sys_addr_dec_chk.sv
module sys_addr_dec_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] addr_i,
  input logic [7:0]  wdata_i,
  input logic        we_i,
  input logic [7:0]  rdata_o,
  input logic [3:0]  region_o,
  input logic        mbc_we_o,
  input logic [14:0] mbc_addr_o,
  input logic [7:0]  mbc_wdata_o,
  input logic        vram_we_o,
  input logic [12:0] vram_off_o,
  input logic        io_we_o,
  input logic [7:0]  ie_o
);
  logic io_hit;
  assign io_hit = (addr_i[15:7] == 9'b1111_1111_0);

  // R1
  rom_region_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> (region_o == 4'd0));

  // R3
  mbc_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_i[15]) |=> (mbc_we_o && mbc_addr_o == $past(addr_i[14:0])
                               && mbc_wdata_o == $past(wdata_i)));

  // R4
  vram_note_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i[15:13] == 3'b100) |=> (vram_we_o && vram_off_o == $past(addr_i[12:0])));

  // R5
  xram_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:13] == 3'b101) |-> (rdata_o == 8'h00));

  // R8
  io_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && io_hit) |=> io_we_o);

  // R10
  ie_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == 16'hFFFF) |=> $stable(ie_o));

  // R12
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({mbc_we_o, vram_we_o, io_we_o}));

  // R12
  no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> (!mbc_we_o && !vram_we_o && !io_we_o));
endmodule

bind sys_addr_dec sys_addr_dec_chk u_chk (.*);

// File: tb/sys_addr_dec_tb.sv
module sys_addr_dec_tb;
  localparam int unsigned BANK_W = 8;
  localparam int unsigned WRAM_BW = 2;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [15:0]        addr_i = '0;
  logic [7:0]         wdata_i = '0;
  logic               we_i = 1'b0;
  logic [7:0]         rdata_o;
  logic [3:0]         region_o;
  logic [13:0]        offset_o;
  logic [BANK_W+13:0] rom_addr_o;
  logic [7:0]         rom_rdata_i;
  logic [BANK_W-1:0]  rom_bank_i = '0;
  logic               mbc_we_o;
  logic [14:0]        mbc_addr_o;
  logic [7:0]         mbc_wdata_o;
  logic               vram_we_o;
  logic [12:0]        vram_off_o;
  logic [WRAM_BW-1:0] wram_bank_i = '0;
  logic [6:0]         io_addr_o;
  logic [7:0]         io_rdata_i;
  logic               io_we_o;
  logic [6:0]         io_waddr_o;
  logic [7:0]         io_wdata_o;
  logic [7:0]         ie_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  // external models
  assign rom_rdata_i = rom_addr_o[7:0] ^ rom_addr_o[21:14];
  assign io_rdata_i  = {1'b1, io_addr_o};

  sys_addr_dec u_dut (.*);

  // {addr, region, offset}
  localparam int NVEC = 19;
  localparam logic [33:0] VEC [NVEC] = '{
    {16'h0000, 4'd0, 14'h0000}, {16'h3FFF, 4'd0, 14'h3FFF},
    {16'h4000, 4'd1, 14'h0000}, {16'h7FFF, 4'd1, 14'h3FFF},
    {16'h8000, 4'd2, 14'h0000}, {16'h9FFF, 4'd2, 14'h1FFF},
    {16'hA123, 4'd3, 14'h0123}, {16'hBFFF, 4'd3, 14'h1FFF},
    {16'hC456, 4'd4, 14'h0456}, {16'hE456, 4'd4, 14'h0456},
    {16'hD789, 4'd5, 14'h0789}, {16'hFDFF, 4'd5, 14'h0DFF},
    {16'hFE00, 4'd6, 14'h0000}, {16'hFE9F, 4'd6, 14'h009F},
    {16'hFF00, 4'd7, 14'h0000}, {16'hFF7F, 4'd7, 14'h007F},
    {16'hFF80, 4'd8, 14'h0000}, {16'hFFFE, 4'd8, 14'h007E},
    {16'hFFFF, 4'd9, 14'h0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // store; returns at the negedge after the capturing edge
  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk_i);
    // R11 reset state
    chk("R11 strobes", {mbc_we_o, vram_we_o, io_we_o}, 0);
    chk("R11 ie", ie_o, 8'h00);
    rst_ni = 1'b1;

    // R1 decode table
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk_i);
      addr_i = VEC[i][33:18];
      #1;
      chk("R1 region", region_o, VEC[i][17:14]);
      chk("R1 offset", offset_o, VEC[i][13:0]);
    end

    // R2 ROM reads
    rom_bank_i = 8'h05;
    rd(16'h1234, d);
    chk("R2 fixed addr", rom_addr_o, 32'h1234);
    chk("R2 fixed data", d, 8'h34);
    rd(16'h5678, d);
    chk("R2 window addr", rom_addr_o, 32'h15678);
    chk("R2 window data", d, 8'h7D);

    // R3 bank-controller command
    wr(16'h2100, 8'h07);
    chk("R3 strobe", mbc_we_o, 1);
    chk("R3 addr", mbc_addr_o, 15'h2100);
    chk("R3 data", mbc_wdata_o, 8'h07);
    chk("R12 others low", {vram_we_o, io_we_o}, 0);
    @(negedge clk_i);
    chk("R12 single pulse", mbc_we_o, 0);

    // R4 video RAM
    wr(16'h8010, 8'hAB);
    chk("R4 strobe", vram_we_o, 1);
    chk("R4 offset", vram_off_o, 13'h0010);
    rd(16'h8010, d);
    chk("R4 readback", d, 8'hAB);

    // R5 external and sprite
    wr(16'hA010, 8'h55);
    chk("R5 no strobe xram", {mbc_we_o, vram_we_o, io_we_o}, 0);
    rd(16'hA010, d);
    chk("R5 xram read", d, 8'h00);
    wr(16'hFE10, 8'h66);
    chk("R5 no strobe oam", {mbc_we_o, vram_we_o, io_we_o}, 0);
    rd(16'hFE10, d);
    chk("R5 oam read", d, 8'h00);

    // R6 work-low mirror
    wr(16'hC020, 8'h11);
    rd(16'hE020, d);
    chk("R6 mirror read", d, 8'h11);
    wr(16'hE021, 8'h22);
    rd(16'hC021, d);
    chk("R6 mirror write", d, 8'h22);

    // R7 switchable banks
    wr(16'hC030, 8'h77);
    wram_bank_i = 2'd3;
    wr(16'hD030, 8'h44);
    wram_bank_i = 2'd2;
    wr(16'hD030, 8'h33);
    wram_bank_i = 2'd3;
    rd(16'hD030, d);
    chk("R7 bank3 kept", d, 8'h44);
    wram_bank_i = 2'd2;
    rd(16'hF030, d);
    chk("R7 mirror bank2", d, 8'h33);
    rd(16'hC030, d);
    chk("R7 low separate", d, 8'h77);
    wram_bank_i = 2'd0;
    wr(16'hD040, 8'h5A);
    wram_bank_i = 2'd1;
    rd(16'hD040, d);
    chk("R7 zero is one", d, 8'h5A);

    // R8 I/O
    rd(16'hFF05, d);
    chk("R8 io addr", io_addr_o, 7'h05);
    chk("R8 io data", d, 8'h85);
    wr(16'hFF12, 8'h9A);
    chk("R8 strobe", io_we_o, 1);
    chk("R8 waddr", io_waddr_o, 7'h12);
    chk("R8 wdata", io_wdata_o, 8'h9A);

    // R9 high RAM
    wr(16'hFF80, 8'hC3);
    wr(16'hFFFE, 8'h3C);
    rd(16'hFF80, d);
    chk("R9 low end", d, 8'hC3);
    rd(16'hFFFE, d);
    chk("R9 high end", d, 8'h3C);

    // R10 interrupt enable
    wr(16'hFFFF, 8'h1F);
    chk("R10 ie out", ie_o, 8'h1F);
    rd(16'hFFFF, d);
    chk("R10 ie read", d, 8'h1F);
    wr(16'hFFFE, 8'hE0);
    chk("R10 ie held", ie_o, 8'h1F);

    // R12 back-to-back: ROM store then I/O store
    @(negedge clk_i);
    addr_i = 16'h6000; wdata_i = 8'h03; we_i = 1'b1;
    @(negedge clk_i);
    chk("R12 first mbc", mbc_we_o, 1);
    chk("R12 first io", io_we_o, 0);
    chk("R3 b2b data", mbc_wdata_o, 8'h03);
    addr_i = 16'hFF40; wdata_i = 8'hD1;
    @(negedge clk_i);
    we_i = 1'b0;
    chk("R12 second mbc", mbc_we_o, 0);
    chk("R12 second io", io_we_o, 1);
    chk("R8 b2b addr", io_waddr_o, 7'h40);
    @(negedge clk_i);
    chk("R12 idle", {mbc_we_o, vram_we_o, io_we_o}, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule